// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the clock enables of a small microcontroller through its power modes. In normal operation every clock runs. A one-cycle SLEEP strobe from the CPU gates only the CPU clock, and the oscillator and the peripheral clock keep running. A one-cycle STOP strobe freezes the oscillator, the CPU clock and the peripheral clock. The STOP strobe takes effect only after software has armed it by writing a key byte to the mode-control register as one whole byte.

While the block is in any low-power state, a hold output freezes the program counter and the CPU registers. The program counter therefore still points at the instruction after the one that caused entry, and RAM and register contents stay intact. The clock for the watchdog, which runs from a separate always-running RC source, stays enabled in every state.

The block leaves SLEEP on an external interrupt and resumes at once. It leaves STOP on an external interrupt, or it leaves any state on an asynchronous reset. Both of these paths restart the oscillator and wait for a stabilization count of 2^STAB_BITS cycles before the clocks are released. The default of 2^18 cycles at 4 MHz gives about 65.5 ms. An internal reset output stays high through a stabilization period that was started by reset.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, the block is in STABILIZE (mode_o = 3): osc_en=1, cpu_clk_en=0, per_clk_en=0, cpu_hold=1, int_rst=1. Mode codes are NORMAL=0, SLEEP=1, STOP=2, STABILIZE=3.
- R2: STABILIZE lasts exactly 2^STAB_BITS clock cycles. The block then enters NORMAL, where osc_en, cpu_clk_en and per_clk_en are 1 and cpu_hold and int_rst are 0.
- R3: A full-byte write of KEY (0x5A) in NORMAL arms STOP. A stop_stb in NORMAL while armed moves the block to STOP on the next clock.
- R4: A stop_stb without the key armed is a no-op, and the block stays in NORMAL. A byte write of any other value disarms the key. A single-bit write disarms it too, even when the resulting register value equals KEY.
- R5: In STOP, osc_en, cpu_clk_en and per_clk_en are all 0 and cpu_hold is 1. wdt_clk_en is 1 in every state once reset is released.
- R6: A sleep_stb in NORMAL moves the block to SLEEP on the next clock. In SLEEP, only cpu_clk_en is 0, osc_en and per_clk_en stay 1, and cpu_hold is 1.
- R7: An ext_irq in SLEEP returns the block to NORMAL on the next clock, with no stabilization wait.
- R8: An ext_irq in STOP moves the block to STABILIZE with int_rst=0. The block reaches NORMAL after the count of R2.
- R9: The key is cleared when the block leaves NORMAL, and no write can arm it outside NORMAL. After any wake-up, a new key write is needed before STOP can be entered again.
- R10: When sleep_stb and stop_stb arrive in the same cycle, STOP wins if the key is armed. If the key is not armed, SLEEP is entered.
- R11: An asynchronous reset during SLEEP or STOP forces STABILIZE with int_rst=1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset and wake-up, active low |
| cfg_byte_we | input | 1 | Full-byte write strobe to the mode-control register |
| cfg_byte_wdata | input | DATA_W | Byte write data |
| cfg_bit_we | input | 1 | Single-bit set/clear strobe to the mode-control register |
| cfg_bit_sel | input | clog2(DATA_W) | Bit index for a single-bit write |
| cfg_bit_val | input | 1 | Value written by a single-bit write |
| sleep_stb | input | 1 | SLEEP instruction strobe |
| stop_stb | input | 1 | STOP instruction strobe |
| ext_irq | input | 1 | External interrupt wake-up |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdt_clk_en | output | 1 | Watchdog RC clock enable |
| cpu_hold | output | 1 | Freezes the program counter and registers |
| int_rst | output | 1 | Internal reset held during reset-started stabilization |
| mode_o | output | 2 | Current mode code |

## Verification
STOP entry is tried with several key histories: no write, a correct byte write, a byte write of another value after the key, a bit write that leaves the value at 0x5A, and a stale key after a wake-up. Together these separate a value-only comparison from the full-byte arming rule. SLEEP and STOP are each left by interrupt and by reset, which tells the immediate resume apart from the stabilized one and shows whether int_rst follows the wake cause. Simultaneous SLEEP and STOP strobes, sent both armed and unarmed, pin down the priority between them.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        M_NORMAL = 2'd0,
        M_SLEEP  = 2'd1,
        M_STOP   = 2'd2,
        M_STAB   = 2'd3
    } lpm_mode_e;

    typedef struct packed {
        lpm_mode_e mode;
        logic      rst_wake;
    } seq_state_t;

endpackage

// File: rtl/lpm_key_reg.sv
module lpm_key_reg #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY    = 8'h5A,
    localparam int               SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_allow,
    input  logic              byte_we,
    input  logic [DATA_W-1:0] byte_wdata,
    input  logic              bit_we,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              bit_val,
    input  logic              key_clr,
    output logic              armed
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              whole;
    } key_t;

    key_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (key_clr) begin
            r_d.val   = '0;
            r_d.whole = 1'b0;
        end else if (wr_allow && byte_we) begin
            r_d.val   = byte_wdata;
            r_d.whole = 1'b1;
        end else if (wr_allow && bit_we) begin
            r_d.val[bit_sel] = bit_val;
            r_d.whole        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign armed = r_q.whole && (r_q.val == KEY);

endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
    parameter int STAB_BITS = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam logic [STAB_BITS-1:0] LAST = {STAB_BITS{1'b1}};

    logic [STAB_BITS-1:0] cnt_q, cnt_d;

    always_comb begin
        if (run) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_stb,
    input  logic      stop_stb,
    input  logic      ext_irq,
    input  logic      armed,
    input  logic      stab_done,
    output lpm_mode_e mode,
    output logic      rst_wake,
    output logic      key_clr
);

    seq_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        unique case (s_q.mode)
            M_NORMAL: begin
                if (stop_stb && armed) begin
                    s_d.mode = M_STOP;
                end else if (sleep_stb) begin
                    s_d.mode = M_SLEEP;
                end
            end
            M_SLEEP: begin
                if (ext_irq) begin
                    s_d.mode = M_NORMAL;
                end
            end
            M_STOP: begin
                if (ext_irq) begin
                    s_d.mode     = M_STAB;
                    s_d.rst_wake = 1'b0;
                end
            end
            M_STAB: begin
                if (stab_done) begin
                    s_d.mode     = M_NORMAL;
                    s_d.rst_wake = 1'b0;
                end
            end
            default: s_d.mode = M_STAB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode     <= M_STAB;
            s_q.rst_wake <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode     = s_q.mode;
    assign rst_wake = s_q.rst_wake;
    assign key_clr  = (s_q.mode != M_NORMAL) || (s_d.mode != M_NORMAL);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] KEY       = 8'h5A,
    parameter int                STAB_BITS = 18,
    localparam int               SEL_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_byte_we,
    input  logic [DATA_W-1:0] cfg_byte_wdata,
    input  logic              cfg_bit_we,
    input  logic [SEL_W-1:0]  cfg_bit_sel,
    input  logic              cfg_bit_val,
    input  logic              sleep_stb,
    input  logic              stop_stb,
    input  logic              ext_irq,
    output logic              osc_en,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              wdt_clk_en,
    output logic              cpu_hold,
    output logic              int_rst,
    output logic [1:0]        mode_o
);

    lpm_mode_e mode_w;
    logic      armed_w;
    logic      stab_done_w;
    logic      rst_wake_w;
    logic      key_clr_w;
    logic      wdt_q, wdt_d;

    lpm_key_reg #(
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_allow   (mode_w == M_NORMAL),
        .byte_we    (cfg_byte_we),
        .byte_wdata (cfg_byte_wdata),
        .bit_we     (cfg_bit_we),
        .bit_sel    (cfg_bit_sel),
        .bit_val    (cfg_bit_val),
        .key_clr    (key_clr_w),
        .armed      (armed_w)
    );

    lpm_stab_cnt #(
        .STAB_BITS (STAB_BITS)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode_w == M_STAB),
        .done  (stab_done_w)
    );

    lpm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_stb (sleep_stb),
        .stop_stb  (stop_stb),
        .ext_irq   (ext_irq),
        .armed     (armed_w),
        .stab_done (stab_done_w),
        .mode      (mode_w),
        .rst_wake  (rst_wake_w),
        .key_clr   (key_clr_w)
    );

    always_comb begin
        wdt_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_q <= 1'b1;
        end else begin
            wdt_q <= wdt_d;
        end
    end

    always_comb begin
        osc_en     = 1'b1;
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        cpu_hold   = 1'b1;
        int_rst    = 1'b0;
        unique case (mode_w)
            M_NORMAL: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                cpu_hold   = 1'b0;
            end
            M_SLEEP: begin
                per_clk_en = 1'b1;
            end
            M_STOP: begin
                osc_en = 1'b0;
            end
            M_STAB: begin
                int_rst = rst_wake_w;
            end
            default: ;
        endcase
    end

    assign wdt_clk_en = wdt_q;
    assign mode_o     = mode_w;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_o,
    input logic       sleep_stb,
    input logic       stop_stb,
    input logic       ext_irq,
    input logic       armed,
    input logic       stab_done,
    input logic       osc_en,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       wdt_clk_en,
    input logic       int_rst
);

    localparam logic [1:0] NRM = 2'd0;
    localparam logic [1:0] SLP = 2'd1;
    localparam logic [1:0] STP = 2'd2;
    localparam logic [1:0] STB = 2'd3;

    a_r2_stab_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == STB && stab_done) |=> (mode_o == NRM));

    a_r3_armed_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == NRM && stop_stb && armed) |=> (mode_o == STP));

    a_r4_unarmed_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == NRM && stop_stb && !sleep_stb && !armed) |=> (mode_o == NRM));

    a_r5_stop_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == STP) |-> (!osc_en && !cpu_clk_en && !per_clk_en && wdt_clk_en));

    a_r6_sleep_gates_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == SLP) |-> (osc_en && per_clk_en && !cpu_clk_en));

    a_r7_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == SLP && ext_irq) |=> (mode_o == NRM));

    a_r8_stop_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == STP && ext_irq) |=> (mode_o == STB && !int_rst));

    a_r9_key_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != NRM) |-> !armed);

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_o     (mode_o),
    .sleep_stb  (sleep_stb),
    .stop_stb   (stop_stb),
    .ext_irq    (ext_irq),
    .armed      (armed_w),
    .stab_done  (stab_done_w),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .wdt_clk_en (wdt_clk_en),
    .int_rst    (int_rst)
);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;

    localparam int SB  = 4;
    localparam int LEN = 1 << SB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       bwe = 1'b0;
    logic [7:0] bdat = '0;
    logic       bitwe = 1'b0;
    logic [2:0] bsel = '0;
    logic       bval = 1'b0;
    logic       slp = 1'b0;
    logic       stp = 1'b0;
    logic       irq = 1'b0;
    logic       osc_en, cpu_clk_en, per_clk_en, wdt_clk_en, cpu_hold, int_rst;
    logic [1:0] mode_o;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;

    // behavioural reference
    int m_st  = 3;
    int m_cnt = 0;
    bit m_arm = 0;
    bit m_rw  = 1;

    always #5 clk = ~clk;

    lpm_ctrl #(.STAB_BITS(SB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_byte_we(bwe), .cfg_byte_wdata(bdat),
        .cfg_bit_we(bitwe), .cfg_bit_sel(bsel), .cfg_bit_val(bval),
        .sleep_stb(slp), .stop_stb(stp), .ext_irq(irq),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .wdt_clk_en(wdt_clk_en), .cpu_hold(cpu_hold), .int_rst(int_rst),
        .mode_o(mode_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 3; m_cnt = 0; m_arm = 0; m_rw = 1;
        end else begin
            case (m_st)
                0: begin
                    bit go_stop;
                    go_stop = stp && m_arm;
                    if (bwe) m_arm = (bdat == 8'h5A);
                    else if (bitwe) m_arm = 0;
                    if (go_stop) m_st = 2;
                    else if (slp) m_st = 1;
                    if (m_st != 0) m_arm = 0;
                end
                1: begin
                    m_arm = 0;
                    if (irq) m_st = 0;
                end
                2: begin
                    m_arm = 0;
                    if (irq) begin m_st = 3; m_rw = 0; m_cnt = 0; end
                end
                default: begin
                    m_arm = 0;
                    if (m_cnt == LEN - 1) begin m_st = 0; m_rw = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            string tag;
            int e_osc, e_cpu, e_per, e_hold, e_ir;
            case (m_st)
                0: tag = "R2";
                1: tag = "R6";
                2: tag = "R5";
                default: tag = m_rw ? "R1" : "R8";
            endcase
            e_osc  = (m_st != 2);
            e_cpu  = (m_st == 0);
            e_per  = (m_st == 0 || m_st == 1);
            e_hold = (m_st != 0);
            e_ir   = (m_st == 3 && m_rw);
            chk({tag, " mode"}, mode_o, m_st);
            chk({tag, " osc_en"}, osc_en, e_osc);
            chk({tag, " cpu_clk_en"}, cpu_clk_en, e_cpu);
            chk({tag, " per_clk_en"}, per_clk_en, e_per);
            chk({tag, " cpu_hold"}, cpu_hold, e_hold);
            chk({tag, " int_rst"}, int_rst, e_ir);
            chk("R5 wdt_clk_en", wdt_clk_en, 1);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit s_slp, input bit s_stp, input bit s_irq);
        @(negedge clk); #1;
        slp = s_slp; stp = s_stp; irq = s_irq;
        @(negedge clk); #1;
        slp = 0; stp = 0; irq = 0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); #1;
        bwe = 1; bdat = d;
        @(negedge clk); #1;
        bwe = 0;
    endtask

    task automatic wr_bit(input int idx, input bit v);
        @(negedge clk); #1;
        bitwe = 1; bsel = 3'(idx); bval = v;
        @(negedge clk); #1;
        bitwe = 0;
    endtask

    task automatic reset_pulse();
        @(negedge clk); #1;
        rst_n = 0;
        #3;
        chk("R11 mode on reset", mode_o, 3);
        chk("R11 int_rst on reset", int_rst, 1);
        @(negedge clk); #1;
        rst_n = 1;
    endtask

    task automatic expect_mode(input string tag, input int exp);
        @(negedge clk); #2;
        chk(tag, mode_o, exp);
    endtask

    initial begin
        rst_n = 0;
        #12;
        chk("R1 reset mode", mode_o, 3);
        chk("R1 reset int_rst", int_rst, 1);
        chk("R1 reset cpu_clk_en", cpu_clk_en, 0);
        chk("R1 reset osc_en", osc_en, 1);
        cmp_on = 1;
        @(negedge clk); #1;
        rst_n = 1;
        idle(LEN + 2);
        chk("R2 normal after count", mode_o, 0);

        pulse(0, 1, 0);
        expect_mode("R4 stop without key", 0);

        wr_byte(8'h5A);
        pulse(0, 1, 0);
        chk("R3 armed stop enters STOP", mode_o, 2);
        chk("R5 stop osc off", osc_en, 0);
        idle(3);
        pulse(0, 0, 1);
        chk("R8 irq wake to stabilize", mode_o, 3);
        chk("R8 int_rst low on irq wake", int_rst, 0);
        idle(LEN + 2);
        chk("R8 normal after count", mode_o, 0);

        pulse(0, 1, 0);
        expect_mode("R9 stale key after wake", 0);

        wr_byte(8'h5A);
        wr_bit(1, 1);
        pulse(0, 1, 0);
        expect_mode("R4 bit write disarms", 0);

        wr_byte(8'h5A);
        wr_byte(8'h33);
        pulse(0, 1, 0);
        expect_mode("R4 other byte disarms", 0);

        pulse(1, 0, 0);
        chk("R6 sleep entry", mode_o, 1);
        chk("R6 sleep per_clk_en", per_clk_en, 1);
        wr_byte(8'h5A);
        pulse(0, 0, 1);
        chk("R7 sleep irq wake immediate", mode_o, 0);
        pulse(0, 1, 0);
        expect_mode("R9 write during sleep ignored", 0);

        wr_byte(8'h5A);
        pulse(1, 1, 0);
        chk("R10 armed both strobes -> STOP", mode_o, 2);
        pulse(0, 0, 1);
        idle(LEN + 2);
        pulse(1, 1, 0);
        chk("R10 unarmed both strobes -> SLEEP", mode_o, 1);

        reset_pulse();
        idle(LEN + 2);
        chk("R11 normal after sleep reset", mode_o, 0);

        wr_byte(8'h5A);
        pulse(0, 1, 0);
        chk("R3 stop again", mode_o, 2);
        reset_pulse();
        idle(LEN + 2);
        chk("R11 normal after stop reset", mode_o, 0);

        idle(2);
        cmp_on = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule